// File: doc/BRIEF.md
# CAN Bus-Join and Initialization Controller

This block is the control-state core of a CAN controller. It decides when the protocol engine may touch the bus. A hardware reset or a watchdog reset puts it into a halted configuration state. Software then configures the node through a small register interface and releases the halt bit. The block follows the received bit stream at each bit-time strobe. It lets the node join the bus only after it sees the required stretch of bus-idle time. It also owns the transmit and receive error counters. When the transmit counter crosses the bus-off limit, it forces the halt bit on its own and enforces a long recovery wait that software cannot cut short.

The block keeps a control byte that holds a halt bit and a configuration-unlock bit. It keeps a 16-bit bit-timing value that can only be written while both bits are set. It also keeps two flags for the last message object, a new-data flag and a remote-pending flag, which stay cleared while the node is halted. The single output `bus_active` is the enable for the rest of the protocol engine. While it is low, the transmit pin stays recessive.

Top module: `can_join_ctrl`

## Requirements
- R1: After `rst_n` or a one-cycle `wdt_rst`, `tx_out` is 1, `tec` and `rec` are 0, `bus_off` is 0, `bus_active` is 0, and the control byte (address 0) reads 0x01 (bit 0 halt = 1, bit 1 unlock = 0).
- R2: A `wdt_rst` pulse leaves the bit-timing value (addresses 1 and 2, output `bit_timing`) unchanged.
- R3: `bus_active` is 0 whenever the halt bit is 1 or the idle wait is incomplete. While `bus_active` is 0, `tx_out` is 1. While `bus_active` is 1, `tx_out` equals `tx_bit`.
- R4: While the halt bit is 1, `last_newdat` and `last_rmtpnd` are held at 0 and set requests are ignored. `tx_err_up` and `rx_err_up` are also ignored, so the counters keep their values.
- R5: A write to address 1 (low byte) or address 2 (high byte) of the bit-timing value takes effect only when control bit 0 and bit 1 are both 1. Otherwise it is ignored.
- R6: After the halt bit is cleared from the normal halted state, the idle wait starts one cycle later. `bus_active` rises right after the strobe that completes 11 consecutive recessive bits. A dominant bit restarts the run.
- R7: Setting the halt bit during the 11-bit wait abandons it. The next release starts a fresh wait from zero.
- R8: In the active state, each `tx_err_up` adds 8 to `tec` and each `rx_err_up` adds 1 to `rec`. `rec` saturates at 255. When `tec` reaches 256 or more, `bus_off` becomes 1 and the halt bit is forced to 1 in the same cycle.
- R9: After bus-off, idle runs are counted only once software has cleared the halt bit. 129 completed runs of 11 recessive bits are then needed. Each run restarts after it completes, and a dominant bit restarts a partial run. Writing the halt bit during the wait neither resets nor shortens it. On the 129th run, `bus_off` clears and both counters return to 0. If the halt bit is 0 at that moment, `bus_active` rises.
- R10: Address 3 reads a status byte: bit 0 = bus-off, bit 1 = bus-off recovery pending (waiting for release or counting), other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wdt_rst | input | 1 | Synchronous watchdog reset request, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| bit_tick | input | 1 | Bit-time sample strobe |
| rx_bit | input | 1 | Received bus level (1 = recessive) |
| tx_bit | input | 1 | Transmit level requested by the protocol engine |
| tx_out | output | 1 | Transmit pin level |
| bus_active | output | 1 | Enable for the protocol engine |
| bus_off | output | 1 | Bus-off flag |
| tx_err_up | input | 1 | Transmit error event |
| rx_err_up | input | 1 | Receive error event |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| bit_timing | output | 16 | Bit-timing configuration value |
| obj_newdat_set | input | 1 | Set request for the last object's new-data flag |
| obj_rmtpnd_set | input | 1 | Set request for the last object's remote-pending flag |
| last_newdat | output | 1 | Last object's new-data flag |
| last_rmtpnd | output | 1 | Last object's remote-pending flag |

## Verification
The properties assume that `wdt_rst` is a single-cycle pulse. They also assume the error events come from the engine only while it is enabled, but the design must tolerate them at any time, and the bench fires them while halted to show they are dropped. `bit_tick` may arrive on any cycle. The stimulus spaces strobes one cycle apart and leaves one idle cycle after each halt release, which matches the one-cycle start latency in R6. Random bit streams are mostly recessive with occasional dominant bits. This mix exercises run restarts without making the 129-run recovery too long.

// File: rtl/can_join_pkg.sv
package can_join_pkg;

  typedef enum logic [2:0] {
    ST_HALT     = 3'd0,
    ST_SYNC     = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_BO_HOLD  = 3'd3,
    ST_BO_RECOV = 3'd4
  } join_state_e;

  localparam int          REG_AW        = 2;
  localparam int          REG_DW        = 8;
  localparam logic [1:0]  A_CTRL        = 2'd0;
  localparam logic [1:0]  A_BT_LO       = 2'd1;
  localparam logic [1:0]  A_BT_HI       = 2'd2;
  localparam logic [1:0]  A_STAT        = 2'd3;
  localparam int          CTRL_HALT_BIT = 0;
  localparam int          CTRL_UNLK_BIT = 1;
  localparam logic [7:0]  CTRL_RST_VAL  = 8'h01;

endpackage

// File: rtl/can_join_rst_sync.sv
module can_join_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/can_join_idle.sv
module can_join_idle #(
  parameter int RUN_LEN = 11,
  parameter int OCC_MAX = 129,
  localparam int RUN_W  = $clog2(RUN_LEN + 1),
  localparam int OCC_W  = $clog2(OCC_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             rx,
  output logic             run_done,
  output logic [OCC_W-1:0] occ_cnt
);

  logic [RUN_W-1:0] run_q, run_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             last_bit;

  assign last_bit = (run_q == RUN_W'(RUN_LEN - 1));
  assign run_done = !clr && tick && rx && last_bit;

  always_comb begin
    run_d = run_q;
    occ_d = occ_q;
    if (clr) begin
      run_d = '0;
      occ_d = '0;
    end else if (tick) begin
      if (!rx) begin
        run_d = '0;
      end else if (last_bit) begin
        run_d = '0;
        if (occ_q != OCC_W'(OCC_MAX)) begin
          occ_d = occ_q + 1'b1;
        end
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
    end else begin
      run_q <= run_d;
      occ_q <= occ_d;
    end
  end

  assign occ_cnt = occ_q;

endmodule

// File: rtl/can_join_errcnt.sv
module can_join_errcnt #(
  parameter int TEC_W   = 9,
  parameter int REC_W   = 8,
  parameter int TX_STEP = 8,
  parameter int BO_LIM  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tx_up,
  input  logic             rx_up,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic             busoff_hit
);

  logic [TEC_W-1:0] tec_q, tec_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic [TEC_W:0]   tec_sum;

  assign tec_sum    = {1'b0, tec_q} + (TEC_W+1)'(TX_STEP);
  assign busoff_hit = en && tx_up && !clr && (tec_sum >= (TEC_W+1)'(BO_LIM));

  always_comb begin
    tec_d = tec_q;
    rec_d = rec_q;
    if (clr) begin
      tec_d = '0;
      rec_d = '0;
    end else if (en) begin
      if (tx_up) begin
        tec_d = tec_sum[TEC_W-1:0];
      end
      if (rx_up && (rec_q != '1)) begin
        rec_d = rec_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_d;
      rec_q <= rec_d;
    end
  end

  assign tec = tec_q;
  assign rec = rec_q;

endmodule

// File: rtl/can_join_regs.sv
module can_join_regs
  import can_join_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              force_halt,
  input  logic              st_bus_off,
  input  logic              st_recov,
  output logic [REG_DW-1:0] rdata,
  output logic              halt,
  output logic              unlock,
  output logic [15:0]       bit_timing
);

  logic [REG_DW-1:0] ctrl_q, ctrl_d;
  logic [7:0]        bt_lo_q, bt_hi_q;
  logic              bt_open;
  logic              bt_lo_we, bt_hi_we;

  assign bt_open  = ctrl_q[CTRL_HALT_BIT] && ctrl_q[CTRL_UNLK_BIT];
  assign bt_lo_we = wr && (addr == A_BT_LO) && bt_open;
  assign bt_hi_we = wr && (addr == A_BT_HI) && bt_open;

  always_comb begin
    ctrl_d = ctrl_q;
    if (soft_clr) begin
      ctrl_d = CTRL_RST_VAL;
    end else begin
      if (wr && (addr == A_CTRL)) begin
        ctrl_d = wdata;
      end
      if (force_halt) begin
        ctrl_d[CTRL_HALT_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST_VAL;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // Bit-timing storage survives every reset by design.
  always_ff @(posedge clk) begin
    if (bt_lo_we) begin
      bt_lo_q <= wdata;
    end
    if (bt_hi_we) begin
      bt_hi_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_BT_LO: rdata = bt_lo_q;
      A_BT_HI: rdata = bt_hi_q;
      default: rdata = {6'b0, st_recov, st_bus_off};
    endcase
  end

  assign halt       = ctrl_q[CTRL_HALT_BIT];
  assign unlock     = ctrl_q[CTRL_UNLK_BIT];
  assign bit_timing = {bt_hi_q, bt_lo_q};

endmodule

// File: rtl/can_join_ctrl.sv
module can_join_ctrl
  import can_join_pkg::*;
#(
  parameter int IDLE_RUN      = 11,
  parameter int BO_IDLE_CNT   = 129,
  parameter int TEC_W         = 9,
  parameter int REC_W         = 8,
  parameter int TX_ERR_STEP   = 8,
  parameter int BUSOFF_LIMIT  = 256,
  localparam int OCC_W        = $clog2(BO_IDLE_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bit_tick,
  input  logic              rx_bit,
  input  logic              tx_bit,
  output logic              tx_out,
  output logic              bus_active,
  output logic              bus_off,
  input  logic              tx_err_up,
  input  logic              rx_err_up,
  output logic [TEC_W-1:0]  tec,
  output logic [REC_W-1:0]  rec,
  output logic [15:0]       bit_timing,
  input  logic              obj_newdat_set,
  input  logic              obj_rmtpnd_set,
  output logic              last_newdat,
  output logic              last_rmtpnd
);

  logic             rst_sync_n;
  join_state_e      state_q, state_d;
  logic             ctrl_halt, ctrl_unlock;
  logic             idle_clr, run_done;
  logic [OCC_W-1:0] occ_cnt;
  logic             recov_done, busoff_hit;
  logic             bus_off_q, bus_off_d;
  logic             recovering;
  logic             cnt_clr;
  logic             newdat_q, newdat_d, rmtpnd_q, rmtpnd_d;

  can_join_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  can_join_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .soft_clr   (wdt_rst),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .force_halt (busoff_hit),
    .st_bus_off (bus_off_q),
    .st_recov   (recovering),
    .rdata      (reg_rdata),
    .halt       (ctrl_halt),
    .unlock     (ctrl_unlock),
    .bit_timing (bit_timing)
  );

  assign idle_clr = !((state_q == ST_SYNC) || (state_q == ST_BO_RECOV));

  can_join_idle #(.RUN_LEN(IDLE_RUN), .OCC_MAX(BO_IDLE_CNT)) u_idle (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (idle_clr),
    .tick     (bit_tick),
    .rx       (rx_bit),
    .run_done (run_done),
    .occ_cnt  (occ_cnt)
  );

  assign recov_done = (state_q == ST_BO_RECOV) && run_done &&
                      (occ_cnt == OCC_W'(BO_IDLE_CNT - 1)) && !wdt_rst;
  assign cnt_clr    = wdt_rst || recov_done;

  can_join_errcnt #(
    .TEC_W   (TEC_W),
    .REC_W   (REC_W),
    .TX_STEP (TX_ERR_STEP),
    .BO_LIM  (BUSOFF_LIMIT)
  ) u_err (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (cnt_clr),
    .en         (bus_active),
    .tx_up      (tx_err_up),
    .rx_up      (rx_err_up),
    .tec        (tec),
    .rec        (rec),
    .busoff_hit (busoff_hit)
  );

  // Join state machine
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HALT:     if (!ctrl_halt) state_d = ST_SYNC;
      ST_SYNC: begin
        if (ctrl_halt)     state_d = ST_HALT;
        else if (run_done) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (busoff_hit)     state_d = ST_BO_HOLD;
        else if (ctrl_halt) state_d = ST_HALT;
      end
      ST_BO_HOLD:  if (!ctrl_halt) state_d = ST_BO_RECOV;
      ST_BO_RECOV: if (recov_done) state_d = ctrl_halt ? ST_HALT : ST_ACTIVE;
      default:     state_d = ST_HALT;
    endcase
    if (wdt_rst) begin
      state_d = ST_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_HALT;
    end else begin
      state_q <= state_d;
    end
  end

  // Bus-off flag
  always_comb begin
    bus_off_d = bus_off_q;
    if (wdt_rst || recov_done) begin
      bus_off_d = 1'b0;
    end else if (busoff_hit) begin
      bus_off_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_off_q <= 1'b0;
    end else begin
      bus_off_q <= bus_off_d;
    end
  end

  // Last message-object flags: untouched by reset, held clear while halted.
  always_comb begin
    newdat_d = newdat_q;
    rmtpnd_d = rmtpnd_q;
    if (ctrl_halt) begin
      newdat_d = 1'b0;
      rmtpnd_d = 1'b0;
    end else begin
      if (obj_newdat_set) newdat_d = 1'b1;
      if (obj_rmtpnd_set) rmtpnd_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    newdat_q <= newdat_d;
    rmtpnd_q <= rmtpnd_d;
  end

  assign recovering  = (state_q == ST_BO_HOLD) || (state_q == ST_BO_RECOV);
  assign bus_active  = (state_q == ST_ACTIVE) && !ctrl_halt;
  assign tx_out      = bus_active ? tx_bit : 1'b1;
  assign bus_off     = bus_off_q;
  assign last_newdat = newdat_q;
  assign last_rmtpnd = rmtpnd_q;

endmodule

// File: rtl/can_join_ctrl_chk.sv
module can_join_ctrl_chk #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int OCC_W       = 8,
  parameter int BO_IDLE_CNT = 129
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_rst,
  input logic             reg_wr,
  input logic             ctrl_halt,
  input logic             ctrl_unlock,
  input logic [15:0]      bit_timing,
  input logic             bus_active,
  input logic             tx_out,
  input logic             bus_off,
  input logic [TEC_W-1:0] tec,
  input logic [REC_W-1:0] rec,
  input logic             last_newdat,
  input logic             last_rmtpnd,
  input logic             busoff_hit,
  input logic             recov_done,
  input logic [OCC_W-1:0] occ_cnt
);

  p_wdt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (ctrl_halt && tec == '0 && rec == '0 && !bus_off));

  p_bt_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst && !reg_wr) |=> $stable(bit_timing));

  p_tx_recessive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> tx_out);

  p_active_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> !ctrl_halt);

  p_flags_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_halt |=> (!last_newdat && !last_rmtpnd));

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_halt && !recov_done && !wdt_rst) |=> ($stable(tec) && $stable(rec)));

  p_bt_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_halt && ctrl_unlock) |=> $stable(bit_timing));

  p_busoff_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_hit && !wdt_rst) |=> (ctrl_halt && bus_off && !bus_active));

  p_recov_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |=> (!bus_off && tec == '0 && rec == '0));

  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= OCC_W'(BO_IDLE_CNT));

endmodule

bind can_join_ctrl can_join_ctrl_chk #(
  .TEC_W       (TEC_W),
  .REC_W       (REC_W),
  .OCC_W       (OCC_W),
  .BO_IDLE_CNT (BO_IDLE_CNT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wdt_rst     (wdt_rst),
  .reg_wr      (reg_wr),
  .ctrl_halt   (ctrl_halt),
  .ctrl_unlock (ctrl_unlock),
  .bit_timing  (bit_timing),
  .bus_active  (bus_active),
  .tx_out      (tx_out),
  .bus_off     (bus_off),
  .tec         (tec),
  .rec         (rec),
  .last_newdat (last_newdat),
  .last_rmtpnd (last_rmtpnd),
  .busoff_hit  (busoff_hit),
  .recov_done  (recov_done),
  .occ_cnt     (occ_cnt)
);

// File: tb/can_join_ctrl_test.sv
module can_join_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bit_tick = 1'b0;
  logic       rx_bit = 1'b1;
  logic       tx_bit = 1'b1;
  logic       tx_out, bus_active, bus_off;
  logic       tx_err_up = 1'b0;
  logic       rx_err_up = 1'b0;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [15:0] bit_timing;
  logic       obj_newdat_set = 1'b0;
  logic       obj_rmtpnd_set = 1'b0;
  logic       last_newdat, last_rmtpnd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int mrun  = 0;
  int mocc  = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  can_join_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_tick(bit_tick), .rx_bit(rx_bit), .tx_bit(tx_bit), .tx_out(tx_out),
    .bus_active(bus_active), .bus_off(bus_off),
    .tx_err_up(tx_err_up), .rx_err_up(rx_err_up), .tec(tec), .rec(rec),
    .bit_timing(bit_timing),
    .obj_newdat_set(obj_newdat_set), .obj_rmtpnd_set(obj_rmtpnd_set),
    .last_newdat(last_newdat), .last_rmtpnd(last_rmtpnd)
  );

  function automatic int exp_tec(int n);
    return n * 8;
  endfunction

  function automatic int exp_rec(int n);
    return (n > 255) ? 255 : n;
  endfunction

  function automatic logic exp_joined(int occ, int need);
    return (occ >= need);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick(logic b);
    bit_tick = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_tick = 1'b0; rx_bit = 1'b1;
    if (!b) mrun = 0;
    else if (mrun == 10) begin mrun = 0; mocc++; end
    else mrun++;
  endtask

  task automatic model_clear();
    mrun = 0; mocc = 0;
  endtask

  task automatic pulse_tx_err();
    tx_err_up = 1'b1; @(negedge clk); tx_err_up = 1'b0;
  endtask

  task automatic pulse_rx_err();
    rx_err_up = 1'b1; @(negedge clk); rx_err_up = 1'b0;
  endtask

  task automatic join_bus();
    wr(2'd0, 8'h00); cyc(1); model_clear();
    repeat (11) tick(1'b1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    chk("R1 tx_out", tx_out, 1);
    chk("R1 tec", tec, 0);
    chk("R1 rec", rec, 0);
    chk("R1 bus_off", bus_off, 0);
    chk("R3 bus_active after reset", bus_active, 0);
    rd(2'd0, rv); chk("R1 ctrl", rv, 8'h01);

    // R5 bit-timing lock
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h5A); wr(2'd2, 8'hC3);
    chk("R5 bt open", bit_timing, 16'hC35A);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h11);
    rd(2'd1, rv); chk("R5 bt lo locked, unlock=0", rv, 8'h5A);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h22);
    rd(2'd2, rv); chk("R5 bt hi locked, halt=0", rv, 8'hC3);
    wr(2'd0, 8'h01); cyc(2);

    // R4 halted: requests ignored
    tx_bit = 1'b0;
    obj_newdat_set = 1'b1; obj_rmtpnd_set = 1'b1;
    pulse_tx_err(); pulse_rx_err();
    obj_newdat_set = 1'b0; obj_rmtpnd_set = 1'b0;
    cyc(1);
    chk("R4 newdat held", last_newdat, 0);
    chk("R4 rmtpnd held", last_rmtpnd, 0);
    chk("R4 tec held", tec, 0);
    chk("R4 rec held", rec, 0);
    chk("R3 tx recessive halted", tx_out, 1);

    // R7 abandoned wait
    wr(2'd0, 8'h00); cyc(1);
    repeat (7) tick(1'b1);
    wr(2'd0, 8'h01); cyc(1);
    wr(2'd0, 8'h00); cyc(1);
    repeat (4) tick(1'b1);
    chk("R7 fresh wait not done", bus_active, 0);
    repeat (6) tick(1'b1);
    chk("R7 ten bits not enough", bus_active, 0);
    tick(1'b1);
    chk("R7 joined on eleventh", bus_active, 1);
    wr(2'd0, 8'h01); cyc(1);

    // R6 random bit streams against bench run model
    for (int t = 0; t < 8; t++) begin
      wr(2'd0, 8'h00); cyc(1); model_clear();
      for (int k = 0; k < 300 && mocc < 1; k++) begin
        tick(($urandom_range(0, 7) != 0) ? 1'b1 : 1'b0);
        chk("R6 join timing", bus_active, exp_joined(mocc, 1));
      end
      wr(2'd0, 8'h01);
      chk("R3 halt drops active", bus_active, 0);
      cyc(1);
    end
    // R6 directed: dominant restarts run
    wr(2'd0, 8'h00); cyc(1); model_clear();
    repeat (10) tick(1'b1);
    tick(1'b0);
    repeat (10) tick(1'b1);
    chk("R6 dominant restart", bus_active, 0);
    tick(1'b1);
    chk("R6 joined", bus_active, 1);

    // R3 tx follows engine when active
    tx_bit = 1'b0; #1;
    chk("R3 tx follows 0", tx_out, 0);
    tx_bit = 1'b1; #1;
    chk("R3 tx follows 1", tx_out, 1);

    // R4 flags set while active, cleared when halted
    obj_newdat_set = 1'b1; @(negedge clk); obj_newdat_set = 1'b0;
    chk("R4 newdat set active", last_newdat, 1);
    wr(2'd0, 8'h01); cyc(1);
    chk("R4 newdat cleared by halt", last_newdat, 0);
    join_bus();
    chk("R6 rejoin", bus_active, 1);

    // R8 error counting and bus-off
    for (int i = 0; i < 10; i++) pulse_tx_err();
    chk("R8 tec step", tec, exp_tec(10));
    for (int i = 0; i < 3; i++) pulse_rx_err();
    chk("R8 rec step", rec, exp_rec(3));
    for (int i = 0; i < 21; i++) pulse_tx_err();
    chk("R8 tec below limit", tec, exp_tec(31));
    chk("R8 not bus-off yet", bus_off, 0);
    pulse_tx_err();
    chk("R8 bus_off set", bus_off, 1);
    chk("R8 tec at limit", tec, exp_tec(32));
    chk("R8 active dropped", bus_active, 0);
    rd(2'd0, rv); chk("R8 halt forced", rv[0], 1);
    rd(2'd3, rv); chk("R10 status bus-off", rv, 8'h03);

    // R9 recovery: runs before release do not count
    repeat (33) tick(1'b1);
    wr(2'd0, 8'h00); cyc(1); model_clear();
    while (mocc < 60) begin
      if ($urandom_range(0, 3) == 0) begin
        repeat ($urandom_range(1, 9)) tick(1'b1);
        tick(1'b0);
      end else begin
        tick(1'b1);
      end
    end
    wr(2'd0, 8'h01);
    while (mocc < 100) tick(1'b1);
    wr(2'd0, 8'h00);
    while (mocc < 128) tick(1'b1);
    chk("R9 128 runs not enough", bus_off, 1);
    chk("R9 still inactive", bus_active, 0);
    chk("R9 tec kept", tec, exp_tec(32));
    while (mocc < 129) tick(1'b1);
    chk("R9 bus_off cleared", bus_off, 0);
    chk("R9 tec cleared", tec, 0);
    chk("R9 rec cleared", rec, 0);
    chk("R9 rejoined", bus_active, 1);
    rd(2'd3, rv); chk("R10 status clear", rv, 8'h00);

    // R1/R2 watchdog reset
    pulse_tx_err(); pulse_tx_err(); pulse_rx_err();
    chk("R8 tec after recovery", tec, exp_tec(2));
    wdt_rst = 1'b1; @(negedge clk); wdt_rst = 1'b0;
    chk("R1 wdt tec", tec, 0);
    chk("R1 wdt rec", rec, 0);
    chk("R1 wdt inactive", bus_active, 0);
    chk("R1 wdt tx", tx_out, 1);
    rd(2'd0, rv); chk("R1 wdt ctrl", rv, 8'h01);
    chk("R2 bit timing kept", bit_timing, 16'hC35A);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule